// File: doc/BRIEF.md
# Speculative Load Checker

This block screens a non-excepting (speculative) load before memory is touched. From a base register value plus either an index register value or a sign-extended immediate, it forms the effective address. It then tests that address and the destination register number against the alignment rules of the access size. Faults never trap. Each fault sets a per-register deferred-error flag, and a separate 64-flag bank is kept for integer and for float registers.

When there is no fault, a deferred flag on a source register carries over to the destination and the load is suppressed. When logging is switched on, every checked load claims the lowest free error-status slot. That slot records the destination, the size, the bank, its own position, the fault kinds and the effective address. A missing free slot is reported as an overflow.

Requests arrive one per cycle on `req_valid`. The response and all state updates appear together one clock later. The memory access itself and the register file data path lie outside the block.

Top module: `spec_load_check`

## Requirements
- R1: Size code 0 or 1 (byte) never faults on alignment. Size code 2 or 3 (halfword) faults when address bit 0 is 1. Size code 4 (word) faults when address bits [1:0] are not zero. Code 7 behaves like a byte.
- R2: Size code 5 (doubleword) gives an address fault when address bits [2:0] are not zero. It gives a register fault when the destination number is odd.
- R3: Size code 6 (quadword) gives an address fault when address bits [3:0] are not zero. It gives a register fault when the destination number is not a multiple of 4.
- R4: On any fault, the destination's flag is set in the bank picked by `req_float` (1 = float bank), and the load is still performed (`rsp_load`=1).
- R5: With no fault, if the base register's flag is set, or the index register's flag is set while `req_use_idx`=1, then the destination flag is set and `rsp_load`=0. Source flags are read from the same bank.
- R6: With no fault and clean sources, the destination flag is cleared and `rsp_load`=1. The index register's flag has no effect when `req_use_idx`=0.
- R7: The effective address is `req_base_val + req_idx_val` when `req_use_idx`=1. Otherwise it is `req_base_val` plus `req_imm` sign-extended. It is stored in the allocated slot's address word.
- R8: When `log_en` and `log_cfg_ok` are both 1, each request writes the lowest-numbered slot whose valid bit is 0 and whose index is below `log_limit`. Otherwise no slot changes.
- R9: The status word of a slot is laid out as follows: bit0 valid=1, bit1 address-valid=1, bit2 float flag, bits[7:5] size code, bits[15:8] destination number, bits[19:16] the slot's own index.
- R10: Status bit3 is 1 only for an address fault, and bit4 is 1 only for a register fault. Both are 0 for a clean load.
- R11: If logging is active and no free slot lies below `log_limit`, then `rsp_ovf`=1 with the response and no slot changes. The flag update still happens.
- R12: `rsp_valid`, `rsp_load` and `rsp_ovf` follow a request by exactly one clock. The flag and slot updates land on that same edge. Everything is 0 after reset.
- R13: Flag vectors put register i at bit i. Each bank is kept as two 32-flag halves, and a request changes at most one flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Load to check this cycle |
| req_size | input | 3 | Access size code |
| req_float | input | 1 | Destination is a float register |
| req_tgt | input | 6 | Destination register number |
| req_base_reg | input | 6 | Base register number |
| req_base_val | input | 32 | Base register value |
| req_use_idx | input | 1 | Use index register instead of immediate |
| req_idx_reg | input | 6 | Index register number |
| req_idx_val | input | 32 | Index register value |
| req_imm | input | 12 | Immediate displacement, signed |
| log_en | input | 1 | Error logging switched on |
| log_cfg_ok | input | 1 | Logging configuration is valid |
| log_limit | input | 3 | Number of slots that may be used |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_load | output | 1 | Load may be performed |
| rsp_ovf | output | 1 | Logging wanted a slot but none was free |
| gr_flags | output | 64 | Integer deferred-error flags |
| fr_flags | output | 64 | Float deferred-error flags |
| slot_stat | output | 80 | Status words, slot i at bits [20i+19:20i] |
| slot_addr | output | 128 | Logged addresses, slot i at bits [32i+31:32i] |

## Verification
The bench uses the defaults: 64 registers per bank, 32-bit addresses, a 12-bit immediate and four log slots. This setup places register 40 in the upper half of a bank, so writes that cross the half boundary are covered. Changing `log_limit` at run time, to 2 and then 3, reaches slot exhaustion and refill after only a few requests. It also shows that the search honours the limit rather than the physical slot count.

// File: rtl/spec_load_pkg.sv
package spec_load_pkg;

  typedef enum logic [2:0] {
    SZ_UB  = 3'd0,
    SZ_SB  = 3'd1,
    SZ_UH  = 3'd2,
    SZ_SH  = 3'd3,
    SZ_W   = 3'd4,
    SZ_D   = 3'd5,
    SZ_Q   = 3'd6,
    SZ_RSV = 3'd7
  } size_e;

  // Error-status word; field order sets the bit positions listed in R9/R10.
  typedef struct packed {
    logic [3:0] slot;
    logic [7:0] rnum;
    logic [2:0] size;
    logic       rerr;
    logic       aerr;
    logic       fr;
    logic       eav;
    logic       vld;
  } stat_t;

  localparam int STAT_W = $bits(stat_t);
  localparam int BODY_W = STAT_W - 4;

endpackage

// File: rtl/spec_load_addr.sv
module spec_load_addr
  import spec_load_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12,
  parameter int RIDX_W = 6
) (
  input  logic [2:0]        size,
  input  logic [RIDX_W-1:0] tgt,
  input  logic [ADDR_W-1:0] base_val,
  input  logic              use_idx,
  input  logic [ADDR_W-1:0] idx_val,
  input  logic [IMM_W-1:0]  imm,
  output logic [ADDR_W-1:0] ea,
  output logic              aerr,
  output logic              rerr
);

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = use_idx ? idx_val : {{(ADDR_W-IMM_W){imm[IMM_W-1]}}, imm};
    ea     = base_val + offset;
    aerr   = 1'b0;
    rerr   = 1'b0;
    case (size_e'(size))
      SZ_UH, SZ_SH: aerr = ea[0];
      SZ_W:         aerr = |ea[1:0];
      SZ_D: begin
        aerr = |ea[2:0];
        rerr = tgt[0];
      end
      SZ_Q: begin
        aerr = |ea[3:0];
        rerr = |tgt[1:0];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/spec_load_flag_bank.sv
module spec_load_flag_bank #(
  parameter int NREG = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] widx,
  input  logic                    wval,
  input  logic [$clog2(NREG)-1:0] ra,
  input  logic [$clog2(NREG)-1:0] rb,
  output logic                    rda,
  output logic                    rdb,
  output logic [NREG-1:0]         flags
);

  localparam int RIDX_W = $clog2(NREG);
  localparam int HALF   = NREG / 2;

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HALF-1:0] q;
    logic [HALF-1:0] d;
    logic            en;

    assign en = we && (widx[RIDX_W-1] == (h != 0));

    always_comb begin
      d = q;
      d[widx[RIDX_W-2:0]] = wval;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign flags[h*HALF +: HALF] = q;
  end

  assign rda = flags[ra];
  assign rdb = flags[rb];

  // R13: one request touches at most one flag
  a_r13_one_flag_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(flags ^ $past(flags)) <= 1);

endmodule

// File: rtl/spec_load_slots.sv
module spec_load_slots
  import spec_load_pkg::*;
#(
  parameter int NSLOTS = 4,
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc,
  input  logic [LIM_W-1:0]         limit,
  input  logic [BODY_W-1:0]        body,
  input  logic [ADDR_W-1:0]        addr,
  output logic                     ovf,
  output logic [NSLOTS*STAT_W-1:0] stat_flat,
  output logic [NSLOTS*ADDR_W-1:0] addr_flat
);

  localparam int SEL_W = (NSLOTS > 1) ? $clog2(NSLOTS) : 1;

  logic [STAT_W-1:0] stat_q [NSLOTS];
  logic [ADDR_W-1:0] addr_q [NSLOTS];
  logic [NSLOTS-1:0] vld_vec;
  logic              found;
  logic [SEL_W-1:0]  sel;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < NSLOTS; i++) begin
      if (!found && (i < int'(limit)) && !vld_vec[i]) begin
        found = 1'b1;
        sel   = SEL_W'(i);
      end
    end
  end

  assign ovf = alloc && !found;

  for (genvar i = 0; i < NSLOTS; i++) begin : g_slot
    logic wr_en;
    assign wr_en = alloc && found && (sel == SEL_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stat_q[i] <= '0;
        addr_q[i] <= '0;
      end else if (wr_en) begin
        stat_q[i] <= {4'(i), body};
        addr_q[i] <= addr;
      end
    end

    assign vld_vec[i]                     = stat_q[i][0];
    assign stat_flat[i*STAT_W +: STAT_W]  = stat_q[i];
    assign addr_flat[i*ADDR_W +: ADDR_W]  = addr_q[i];
  end

  // R8: at most one slot is claimed per request
  a_r8_single_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld_vec & ~$past(vld_vec)) <= 1);

  // R11: an overflow leaves every slot untouched
  a_r11_ovf_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> $stable(vld_vec));

endmodule

// File: rtl/spec_load_check.sv
module spec_load_check
  import spec_load_pkg::*;
#(
  parameter int NREG   = 64,
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12,
  parameter int NSLOTS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [2:0]               req_size,
  input  logic                     req_float,
  input  logic [$clog2(NREG)-1:0]  req_tgt,
  input  logic [$clog2(NREG)-1:0]  req_base_reg,
  input  logic [ADDR_W-1:0]        req_base_val,
  input  logic                     req_use_idx,
  input  logic [$clog2(NREG)-1:0]  req_idx_reg,
  input  logic [ADDR_W-1:0]        req_idx_val,
  input  logic [IMM_W-1:0]         req_imm,
  input  logic                     log_en,
  input  logic                     log_cfg_ok,
  input  logic [$clog2(NSLOTS+1)-1:0] log_limit,
  output logic                     rsp_valid,
  output logic                     rsp_load,
  output logic                     rsp_ovf,
  output logic [NREG-1:0]          gr_flags,
  output logic [NREG-1:0]          fr_flags,
  output logic [NSLOTS*STAT_W-1:0] slot_stat,
  output logic [NSLOTS*ADDR_W-1:0] slot_addr
);

  localparam int RIDX_W = $clog2(NREG);
  localparam int LIM_W  = $clog2(NSLOTS+1);

  logic [ADDR_W-1:0] ea;
  logic              aerr, rerr, fault;
  logic              gr_a, gr_b, fr_a, fr_b;
  logic              src_flag, new_flag, load_go;
  logic              log_on, ovf;
  stat_t             entry;

  spec_load_addr #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .RIDX_W(RIDX_W)) addr_i (
    .size(req_size), .tgt(req_tgt), .base_val(req_base_val),
    .use_idx(req_use_idx), .idx_val(req_idx_val), .imm(req_imm),
    .ea(ea), .aerr(aerr), .rerr(rerr)
  );

  spec_load_flag_bank #(.NREG(NREG)) gr_bank_i (
    .clk(clk), .rst_n(rst_n), .we(req_valid && !req_float), .widx(req_tgt),
    .wval(new_flag), .ra(req_base_reg), .rb(req_idx_reg),
    .rda(gr_a), .rdb(gr_b), .flags(gr_flags)
  );

  spec_load_flag_bank #(.NREG(NREG)) fr_bank_i (
    .clk(clk), .rst_n(rst_n), .we(req_valid && req_float), .widx(req_tgt),
    .wval(new_flag), .ra(req_base_reg), .rb(req_idx_reg),
    .rda(fr_a), .rdb(fr_b), .flags(fr_flags)
  );

  always_comb begin
    fault    = aerr || rerr;
    src_flag = req_float ? (fr_a || (req_use_idx && fr_b))
                         : (gr_a || (req_use_idx && gr_b));
    new_flag = fault || src_flag;
    load_go  = fault || !src_flag;
    log_on   = req_valid && log_en && log_cfg_ok;
    entry      = '0;
    entry.vld  = 1'b1;
    entry.eav  = 1'b1;
    entry.fr   = req_float;
    entry.aerr = aerr;
    entry.rerr = rerr;
    entry.size = req_size;
    entry.rnum = 8'(req_tgt);
  end

  spec_load_slots #(.NSLOTS(NSLOTS), .ADDR_W(ADDR_W), .LIM_W(LIM_W)) slots_i (
    .clk(clk), .rst_n(rst_n), .alloc(log_on), .limit(log_limit),
    .body(entry[BODY_W-1:0]), .addr(ea), .ovf(ovf),
    .stat_flat(slot_stat), .addr_flat(slot_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_load  <= 1'b0;
      rsp_ovf   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_load  <= req_valid && load_go;
      rsp_ovf   <= ovf;
    end
  end

  // R4: a detected fault flags the destination in its bank
  a_r4_fault_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (aerr || rerr) |=>
      ($past(req_float) ? fr_flags[$past(req_tgt)] : gr_flags[$past(req_tgt)]));

  // R5: a suppressed load always leaves its destination flagged
  a_r5_suppress_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_load |->
      ($past(req_float) ? fr_flags[$past(req_tgt)] : gr_flags[$past(req_tgt)]));

  // R12: response follows the request by one clock
  a_r12_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r12_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_ovf);

  // R11: overflow only comes from a logged request
  a_r11_ovf_when_logging: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ovf |-> rsp_valid && $past(log_en) && $past(log_cfg_ok));

endmodule

// File: tb/spec_load_check_tb_top.sv
module spec_load_check_tb_top;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_float, req_use_idx, log_en, log_cfg_ok;
  logic [2:0]   req_size, log_limit;
  logic [5:0]   req_tgt, req_base_reg, req_idx_reg;
  logic [31:0]  req_base_val, req_idx_val;
  logic [11:0]  req_imm;
  logic         rsp_valid, rsp_load, rsp_ovf;
  logic [63:0]  gr_flags, fr_flags;
  logic [79:0]  slot_stat;
  logic [127:0] slot_addr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  spec_load_check dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
    .req_float(req_float), .req_tgt(req_tgt), .req_base_reg(req_base_reg),
    .req_base_val(req_base_val), .req_use_idx(req_use_idx),
    .req_idx_reg(req_idx_reg), .req_idx_val(req_idx_val), .req_imm(req_imm),
    .log_en(log_en), .log_cfg_ok(log_cfg_ok), .log_limit(log_limit),
    .rsp_valid(rsp_valid), .rsp_load(rsp_load), .rsp_ovf(rsp_ovf),
    .gr_flags(gr_flags), .fr_flags(fr_flags),
    .slot_stat(slot_stat), .slot_addr(slot_addr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] mk(input logic fr, input logic ae, input logic re,
                                     input logic [2:0] sz, input logic [7:0] rn,
                                     input logic [3:0] idx);
    return {idx, rn, sz, re, ae, fr, 1'b1, 1'b1};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_size = 3'd0; req_float = 1'b0;
    req_tgt = '0; req_base_reg = '0; req_idx_reg = '0; req_use_idx = 1'b0;
    req_base_val = '0; req_idx_val = '0; req_imm = '0;
    log_en = 1'b0; log_cfg_ok = 1'b0; log_limit = 3'd4;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Drives one request; returns at the next falling edge, when its response is visible.
  task automatic issue(input logic [2:0] sz, input logic flt, input logic [5:0] tgt,
                       input logic [5:0] breg, input logic [31:0] bval,
                       input logic uidx, input logic [5:0] ireg,
                       input logic [31:0] ival, input logic [11:0] imm);
    @(negedge clk);
    req_valid = 1'b1; req_size = sz; req_float = flt; req_tgt = tgt;
    req_base_reg = breg; req_base_val = bval; req_use_idx = uidx;
    req_idx_reg = ireg; req_idx_val = ival; req_imm = imm;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R12 reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R13 reset gr_flags", gr_flags, 64'd0);
    chk("R13 reset fr_flags", fr_flags, 64'd0);
    chk("R8 reset slot_stat", 64'(slot_stat[63:0]), 64'd0);
  endtask

  task automatic t_align();
    issue(3'd0, 0, 6'd1, 6'd0, 32'h13, 0, 6'd0, 0, 12'h0);
    chk("R12 rsp_valid", 64'(rsp_valid), 64'd1);
    chk("R1 byte odd no flag", 64'(gr_flags[1]), 64'd0);
    chk("R1 byte load", 64'(rsp_load), 64'd1);
    issue(3'd2, 0, 6'd2, 6'd0, 32'h21, 0, 6'd0, 0, 12'h0);
    chk("R1 half odd flag", 64'(gr_flags[2]), 64'd1);
    chk("R4 fault still loads", 64'(rsp_load), 64'd1);
    issue(3'd3, 0, 6'd3, 6'd0, 32'h22, 0, 6'd0, 0, 12'h0);
    chk("R1 half even", 64'(gr_flags[3]), 64'd0);
    issue(3'd4, 0, 6'd4, 6'd0, 32'h42, 0, 6'd0, 0, 12'h0);
    chk("R1 word misaligned", 64'(gr_flags[4]), 64'd1);
    issue(3'd4, 0, 6'd5, 6'd0, 32'h44, 0, 6'd0, 0, 12'h0);
    chk("R1 word aligned", 64'(gr_flags[5]), 64'd0);
    issue(3'd7, 0, 6'd9, 6'd0, 32'h47, 0, 6'd0, 0, 12'h0);
    chk("R1 code 7 as byte", 64'(gr_flags[9]), 64'd0);
  endtask

  task automatic t_pair();
    issue(3'd5, 0, 6'd6, 6'd0, 32'h104, 0, 6'd0, 0, 12'h0);
    chk("R2 dword addr fault", 64'(gr_flags[6]), 64'd1);
    issue(3'd5, 0, 6'd7, 6'd0, 32'h108, 0, 6'd0, 0, 12'h0);
    chk("R2 dword odd reg", 64'(gr_flags[7]), 64'd1);
    issue(3'd5, 0, 6'd8, 6'd0, 32'h108, 0, 6'd0, 0, 12'h0);
    chk("R2 dword clean", 64'(gr_flags[8]), 64'd0);
    issue(3'd6, 0, 6'd12, 6'd0, 32'h208, 0, 6'd0, 0, 12'h0);
    chk("R3 quad addr fault", 64'(gr_flags[12]), 64'd1);
    issue(3'd6, 0, 6'd14, 6'd0, 32'h210, 0, 6'd0, 0, 12'h0);
    chk("R3 quad reg fault", 64'(gr_flags[14]), 64'd1);
    issue(3'd6, 0, 6'd16, 6'd0, 32'h210, 0, 6'd0, 0, 12'h0);
    chk("R3 quad clean", 64'(gr_flags[16]), 64'd0);
  endtask

  task automatic t_prop();
    issue(3'd0, 0, 6'd20, 6'd6, 32'h0, 0, 6'd0, 0, 12'h0);
    chk("R5 base flag propagates", 64'(gr_flags[20]), 64'd1);
    chk("R5 load suppressed", 64'(rsp_load), 64'd0);
    issue(3'd0, 0, 6'd21, 6'd8, 32'h0, 1, 6'd7, 0, 12'h0);
    chk("R5 index flag propagates", 64'(gr_flags[21]), 64'd1);
    chk("R5 index suppress", 64'(rsp_load), 64'd0);
    issue(3'd0, 0, 6'd22, 6'd8, 32'h0, 0, 6'd7, 0, 12'h0);
    chk("R6 index ignored on imm", 64'(gr_flags[22]), 64'd0);
    chk("R6 load done", 64'(rsp_load), 64'd1);
    issue(3'd0, 0, 6'd6, 6'd8, 32'h0, 0, 6'd0, 0, 12'h0);
    chk("R6 clean clears flag", 64'(gr_flags[6]), 64'd0);
    issue(3'd2, 0, 6'd23, 6'd7, 32'h1, 0, 6'd0, 0, 12'h0);
    chk("R4 fault over propagation", 64'(rsp_load), 64'd1);
    chk("R4 fault flag", 64'(gr_flags[23]), 64'd1);
  endtask

  task automatic t_float();
    logic [63:0] gr_before;
    gr_before = gr_flags;
    issue(3'd2, 1, 6'd40, 6'd0, 32'h3, 0, 6'd0, 0, 12'h0);
    chk("R4 float bank set", 64'(fr_flags[40]), 64'd1);
    chk("R13 upper half bit", 64'(fr_flags[63:32]), 64'h100);
    chk("R4 int bank untouched", gr_flags, gr_before);
    issue(3'd0, 1, 6'd41, 6'd40, 32'h0, 0, 6'd0, 0, 12'h0);
    chk("R5 float propagation", 64'(fr_flags[41]), 64'd1);
    chk("R5 float suppress", 64'(rsp_load), 64'd0);
    issue(3'd0, 0, 6'd42, 6'd40, 32'h0, 0, 6'd0, 0, 12'h0);
    chk("R5 bank separation", 64'(gr_flags[42]), 64'd0);
    chk("R5 bank separation load", 64'(rsp_load), 64'd1);
  endtask

  task automatic t_log();
    do_reset();
    log_en = 1'b1; log_cfg_ok = 1'b1; log_limit = 3'd4;
    issue(3'd5, 1, 6'd5, 6'd0, 32'h1000, 0, 6'd0, 0, 12'h003);
    chk("R9 slot0 status", 64'(slot_stat[19:0]), 64'(mk(1, 1, 1, 3'd5, 8'd5, 4'd0)));
    chk("R7 slot0 address imm", 64'(slot_addr[31:0]), 64'h1003);
    chk("R11 no ovf", 64'(rsp_ovf), 64'd0);
    issue(3'd4, 0, 6'd9, 6'd0, 32'h2000, 1, 6'd3, 32'h30, 12'h0);
    chk("R10 slot1 clean", 64'(slot_stat[39:20]), 64'(mk(0, 0, 0, 3'd4, 8'd9, 4'd1)));
    chk("R7 slot1 address idx", 64'(slot_addr[63:32]), 64'h2030);
    issue(3'd0, 0, 6'd10, 6'd0, 32'h100, 0, 6'd0, 0, 12'hFFC);
    chk("R8 slot2 next free", 64'(slot_stat[59:40]), 64'(mk(0, 0, 0, 3'd0, 8'd10, 4'd2)));
    chk("R7 negative imm", 64'(slot_addr[95:64]), 64'hFC);
    log_cfg_ok = 1'b0;
    issue(3'd0, 0, 6'd11, 6'd0, 32'h0, 0, 6'd0, 0, 12'h0);
    chk("R8 invalid cfg no log", 64'(slot_stat[79:60]), 64'd0);
    log_cfg_ok = 1'b1; log_en = 1'b0;
    issue(3'd0, 0, 6'd11, 6'd0, 32'h0, 0, 6'd0, 0, 12'h0);
    chk("R8 disabled no log", 64'(slot_stat[79:60]), 64'd0);
    chk("R11 no ovf when off", 64'(rsp_ovf), 64'd0);
  endtask

  task automatic t_ovf();
    do_reset();
    log_en = 1'b1; log_cfg_ok = 1'b1; log_limit = 3'd2;
    issue(3'd0, 0, 6'd1, 6'd0, 32'h0, 0, 6'd0, 0, 12'h0);
    issue(3'd0, 0, 6'd2, 6'd0, 32'h0, 0, 6'd0, 0, 12'h0);
    chk("R11 ovf clear while space", 64'(rsp_ovf), 64'd0);
    issue(3'd2, 0, 6'd30, 6'd0, 32'h1, 0, 6'd0, 0, 12'h0);
    chk("R11 ovf raised", 64'(rsp_ovf), 64'd1);
    chk("R11 slot2 untouched", 64'(slot_stat[59:40]), 64'd0);
    chk("R11 flag still set", 64'(gr_flags[30]), 64'd1);
    log_limit = 3'd3;
    issue(3'd0, 0, 6'd31, 6'd0, 32'h0, 0, 6'd0, 0, 12'h0);
    chk("R8 limit raised refills", 64'(slot_stat[59:40]), 64'(mk(0, 0, 0, 3'd0, 8'd31, 4'd2)));
    chk("R11 ovf cleared", 64'(rsp_ovf), 64'd0);
  endtask

  initial begin
    t_reset();
    t_align();
    t_pair();
    t_prop();
    t_float();
    t_log();
    t_ovf();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule